// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 62 level-sensitive interrupt lines, samples each one once per clock, and raises one request to the processor. A channel can win only when it is enabled in a mask that software changes through write-one set and write-one clear command registers. Among the channels that are both active and enabled, the one with the lowest priority value wins. The request is raised only when that winner has strictly higher priority than the interrupt being serviced.

The handler first reads the priority-encoding register, which returns the winning vector. That read also copies the vector into an interrupt-number register, which clears itself when read, and marks the winner's priority as in service. A write of any value to the end-of-service register clears the in-service record, so equal- and lower-priority channels can request again. Everything is reached over a plain 32-bit register bus with separate read and write strobes. A read returns its data one clock after the strobe.

Top module: `vpic_top`

## Requirements
- R1: After a synchronous active-low reset, all channels are masked, nothing is in service, `irq_o` is low, the priority-encoding and interrupt-number registers read 0, and every priority field reads 7.
- R2: Writing to 0x130 (channels 0-31, bit n = channel n) or 0x134 (channels 32-61, bit n = channel 32+n) enables each channel whose bit is 1. Bits written as 0, and bits above channel 61, leave the mask unchanged. The mask reads back at 0x128 (low word) and 0x12C (high word).
- R3: Writing to 0x138 (low word) or 0x13C (high word) disables each channel whose bit is 1 and leaves all other channels unchanged.
- R4: 0x100/0x104 return the sampled source levels and 0x108/0x10C return sampled-and-enabled, using the same bit layout as the mask. A source change appears one clock after it is applied. Writes to these registers have no effect.
- R5: Channel n's 3-bit priority sits at address 4*(n/4), bits 8*(n%4)+2 down to 8*(n%4). It is writable and reads back with all other bits 0. Value 0 is the highest priority.
- R6: The winner is the active, enabled channel with the lowest priority value. Equal values go to the lower channel number. Channel 0 can never win.
- R7: A read of 0x118 returns the winner's number in bits 7:2, with all other bits 0, when `irq_o` is high. It returns 0 otherwise.
- R8: A read of 0x118 loads the interrupt-number register with the value it reports. That register reads at 0x120 in bits 5:0 and returns to 0 after each read.
- R9: `irq_o` is high exactly when a winner exists and either nothing is in service or the winner's priority value is strictly below the in-service value.
- R10: A read of 0x118 while `irq_o` is high records the winner's priority as in service, replacing any earlier record. A write of any data to 0x150 clears the record.
- R11: Read data appears on `bus_rdata_o` one clock after `bus_rd_i`. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 62 | Level-sensitive interrupt sources |
| bus_addr_i | input | 12 | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A read of the priority-encoding register and the arrival of a new, higher-priority source can happen on the same clock edge. The bench provokes this by raising channel 33 (priority 0) in the same cycle as the read, while channel 5 (priority 3) is the current winner. The read must report channel 5 and put priority 3 in service, because it uses the state sampled before that edge. The newly sampled channel 33 must then preempt, so `irq_o` stays high in the next cycle and a further read reports vector 33.

// File: rtl/vpic_pkg.sv
// Package: shared register offsets of the vectored interrupt controller.
// Assumes a 32-bit data bus and byte addresses, with registers on word boundaries.
package vpic_pkg;
    localparam int unsigned BUS_W        = 32;
    localparam int unsigned OFS_RAW_LO   = 'h100;
    localparam int unsigned OFS_RAW_HI   = 'h104;
    localparam int unsigned OFS_ACT_LO   = 'h108;
    localparam int unsigned OFS_ACT_HI   = 'h10C;
    localparam int unsigned OFS_PRIO_RD  = 'h118;
    localparam int unsigned OFS_NUM      = 'h120;
    localparam int unsigned OFS_MASK_LO  = 'h128;
    localparam int unsigned OFS_MASK_HI  = 'h12C;
    localparam int unsigned OFS_MSET_LO  = 'h130;
    localparam int unsigned OFS_MSET_HI  = 'h134;
    localparam int unsigned OFS_MCLR_LO  = 'h138;
    localparam int unsigned OFS_MCLR_HI  = 'h13C;
    localparam int unsigned OFS_EOS      = 'h150;
endpackage

// File: rtl/vpic_mask_bank.sv
// Module: per-channel enable mask with write-one set and write-one clear commands.
// Assumes set and clear are never strobed in the same cycle, because they have different addresses.
// Channels 0-31 take the low command word and the rest take the high word.
module vpic_mask_bank #(
    parameter int unsigned NUM_CH = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_lo_we,
    input  logic              set_hi_we,
    input  logic              clr_lo_we,
    input  logic              clr_hi_we,
    input  logic [31:0]       wdata_i,
    output logic [NUM_CH-1:0] mask_o
);
    localparam int unsigned HI_W = NUM_CH - 32;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int unsigned BIT = g % 32;
        logic set_we, clr_we;
        if (g < 32) begin : g_lo
            assign set_we = set_lo_we;
            assign clr_we = clr_lo_we;
        end else begin : g_hi
            assign set_we = set_hi_we;
            assign clr_we = clr_hi_we;
        end
        // Update one enable bit from the set or clear command.
        always_ff @(posedge clk) begin
            if (!rst_n)                     mask_o[g] <= 1'b0;
            else if (set_we && wdata_i[BIT]) mask_o[g] <= 1'b1;
            else if (clr_we && wdata_i[BIT]) mask_o[g] <= 1'b0;
        end
    end

    assert_set_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_lo_we |=> ((mask_o[31:0] & $past(wdata_i)) == $past(wdata_i)));
    assert_set_keeps_others_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_lo_we |=> ((mask_o[31:0] & ~$past(wdata_i)) == ($past(mask_o[31:0]) & ~$past(wdata_i))));
    assert_clear_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hi_we |=> ((mask_o[NUM_CH-1:32] & $past(wdata_i[HI_W-1:0])) == '0));
endmodule

// File: rtl/vpic_prio_store.sv
// Module: 3-bit priority fields, four channels per 32-bit word, each in its own byte.
// Assumes PRIO_W <= 8. The fields reset to all ones (lowest priority). The word read is combinational.
module vpic_prio_store #(
    parameter int unsigned NUM_CH = 62,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned WIDX_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [WIDX_W-1:0]             widx_i,
    input  logic [31:0]                   wdata_i,
    output logic [NUM_CH-1:0][PRIO_W-1:0] prio_o,
    output logic [31:0]                   rword_o
);
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int unsigned WORD = g / 4;
        localparam int unsigned SLOT = g % 4;
        // Load this channel's field when its word is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   prio_o[g] <= '1;
            else if (we_i && widx_i == WIDX_W'(WORD))     prio_o[g] <= wdata_i[8*SLOT +: PRIO_W];
        end
    end

    // Assemble the addressed word for read-back, with absent channels left as zero.
    always_comb begin
        rword_o = '0;
        for (int s = 0; s < 4; s++) begin
            if (int'(widx_i) * 4 + s < int'(NUM_CH))
                rword_o[8*s +: PRIO_W] = prio_o[int'(widx_i) * 4 + s];
        end
    end
endmodule

// File: rtl/vpic_selector.sv
// Module: picks the winning channel among the candidates.
// The lowest priority value wins, ties go to the lower channel number, and channel 0 is never chosen.
// Purely combinational; its depth is a linear scan of NUM_CH compare stages.
module vpic_selector #(
    parameter int unsigned NUM_CH = 62,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ID_W   = 6
) (
    input  logic [NUM_CH-1:0]             cand_i,
    input  logic [NUM_CH-1:0][PRIO_W-1:0] prio_i,
    output logic                          found_o,
    output logic [ID_W-1:0]               win_id_o,
    output logic [PRIO_W-1:0]             win_prio_o
);
    logic unused_ch0;
    assign unused_ch0 = cand_i[0] ^ (^prio_i[0]);

    // Scan from the top channel down; "<=" lets the lower index win a tie.
    always_comb begin
        found_o    = 1'b0;
        win_id_o   = '0;
        win_prio_o = '1;
        for (int i = NUM_CH - 1; i >= 1; i--) begin
            if (cand_i[i] && (!found_o || prio_i[i] <= win_prio_o)) begin
                found_o    = 1'b1;
                win_id_o   = ID_W'(i);
                win_prio_o = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
// Module: vectored prioritized interrupt controller, top level.
// Samples the sources, decodes the register bus, holds the vector registers and the
// one-deep in-service record, and drives the processor request.
// Assumes 32 < NUM_CH <= 64 and a single bus access per cycle.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_CH = 62,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned ID_W      = $clog2(NUM_CH);
    localparam int unsigned CTL_WORDS = (NUM_CH + 3) / 4;
    localparam int unsigned WIDX_W    = (CTL_WORDS > 1) ? $clog2(CTL_WORDS) : 1;

    logic [NUM_CH-1:0]             src_q, mask, cand;
    logic [NUM_CH-1:0][PRIO_W-1:0] prio;
    logic [31:0]                   ctl_word, rd_val;
    logic [63:0]                   pend64, act64, mask64;
    logic                          win_found;
    logic [ID_W-1:0]               win_id, vec_now, num_q;
    logic [PRIO_W-1:0]             win_prio, isv_prio;
    logic                          isv_valid;
    logic                          hit_ctl, prio_rd, num_rd, eos_wr;

    assign hit_ctl = bus_addr_i < ADDR_W'(CTL_WORDS * 4);
    assign prio_rd = bus_rd_i && bus_addr_i == ADDR_W'(OFS_PRIO_RD);
    assign num_rd  = bus_rd_i && bus_addr_i == ADDR_W'(OFS_NUM);
    assign eos_wr  = bus_wr_i && bus_addr_i == ADDR_W'(OFS_EOS);

    // Register the level-sensitive sources once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    vpic_mask_bank #(.NUM_CH(NUM_CH)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_lo_we (bus_wr_i && bus_addr_i == ADDR_W'(OFS_MSET_LO)),
        .set_hi_we (bus_wr_i && bus_addr_i == ADDR_W'(OFS_MSET_HI)),
        .clr_lo_we (bus_wr_i && bus_addr_i == ADDR_W'(OFS_MCLR_LO)),
        .clr_hi_we (bus_wr_i && bus_addr_i == ADDR_W'(OFS_MCLR_HI)),
        .wdata_i   (bus_wdata_i),
        .mask_o    (mask)
    );

    vpic_prio_store #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .WIDX_W(WIDX_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_wr_i && hit_ctl),
        .widx_i  (bus_addr_i[2 +: WIDX_W]),
        .wdata_i (bus_wdata_i),
        .prio_o  (prio),
        .rword_o (ctl_word)
    );

    assign cand = src_q & mask;

    vpic_selector #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
        .cand_i     (cand),
        .prio_i     (prio),
        .found_o    (win_found),
        .win_id_o   (win_id),
        .win_prio_o (win_prio)
    );

    // Request when the winner is strictly more urgent than the interrupt in service.
    assign irq_o   = win_found && (!isv_valid || win_prio < isv_prio);
    assign vec_now = irq_o ? win_id : '0;

    // Widen the per-channel vectors to two full words for read-back.
    always_comb begin
        pend64 = '0;
        act64  = '0;
        mask64 = '0;
        pend64[NUM_CH-1:0] = src_q;
        act64[NUM_CH-1:0]  = cand;
        mask64[NUM_CH-1:0] = mask;
    end

    // Select the read data for the addressed register.
    always_comb begin
        rd_val = '0;
        if (hit_ctl) begin
            rd_val = ctl_word;
        end else begin
            case (bus_addr_i)
                ADDR_W'(OFS_RAW_LO):  rd_val = pend64[31:0];
                ADDR_W'(OFS_RAW_HI):  rd_val = pend64[63:32];
                ADDR_W'(OFS_ACT_LO):  rd_val = act64[31:0];
                ADDR_W'(OFS_ACT_HI):  rd_val = act64[63:32];
                ADDR_W'(OFS_PRIO_RD): rd_val = {{(BUS_W-ID_W-2){1'b0}}, vec_now, 2'b00};
                ADDR_W'(OFS_NUM):     rd_val = {{(BUS_W-ID_W){1'b0}}, num_q};
                ADDR_W'(OFS_MASK_LO): rd_val = mask64[31:0];
                ADDR_W'(OFS_MASK_HI): rd_val = mask64[63:32];
                default:              rd_val = '0;
            endcase
        end
    end

    // Register the read data; it is zero in cycles with no read.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_val;
        else               bus_rdata_o <= '0;
    end

    // The interrupt-number register loads on a priority read and clears on its own read.
    always_ff @(posedge clk) begin
        if (!rst_n)       num_q <= '0;
        else if (prio_rd) num_q <= vec_now;
        else if (num_rd)  num_q <= '0;
    end

    // One-deep in-service record: set on an acknowledging read, cleared by end of service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isv_valid <= 1'b0;
            isv_prio  <= '1;
        end else if (prio_rd && irq_o) begin
            isv_valid <= 1'b1;
            isv_prio  <= win_prio;
        end else if (eos_wr) begin
            isv_valid <= 1'b0;
        end
    end

    assert_winner_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_found |-> (cand[win_id] && win_id != '0));
    assert_prio_read_format_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prio_rd |=> (bus_rdata_o[31:8] == '0 && bus_rdata_o[1:0] == 2'b00));
    assert_vector_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_rd && irq_o) |=> num_q == $past(win_id));
    assert_num_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        num_rd |=> num_q == '0);
    assert_service_masks_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_rd && irq_o) |=> irq_o == (win_found && win_prio < $past(win_prio)));
    assert_eos_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eos_wr |=> !isv_valid);
endmodule

// File: tb/vpic_top_test.sv
// Scoreboard bench: read tasks queue the expected data; a monitor compares the data the cycle after each read.
module vpic_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [61:0] src = '0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vpic_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Issue one read and queue its expected data; called and returns at a falling edge.
    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string t);
        addr = a;
        rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic irq_chk(input logic e, input string t);
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
        end
    endtask

    // Monitor: after each edge that saw a read, pop the expected data and compare.
    always @(posedge clk) begin
        if (rd) begin
            #1;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected read actual=%h expected=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        irq_chk(1'b0, "R1 reset");
        rd_chk(12'h128, 32'h0, "R1 mask lo");
        rd_chk(12'h12C, 32'h0, "R1 mask hi");
        rd_chk(12'h120, 32'h0, "R1 number reg");
        rd_chk(12'h118, 32'h0, "R1 prio reg");
        rd_chk(12'h000, 32'h07070707, "R1 prio defaults");
        rd_chk(12'h03C, 32'h00000707, "R1 last ctl word");

        // R2 enable commands
        wr_reg(12'h130, 32'h000000F6);
        rd_chk(12'h128, 32'h000000F6, "R2 set lo");
        wr_reg(12'h130, 32'h00000001);
        rd_chk(12'h128, 32'h000000F7, "R2 zero bits keep");
        wr_reg(12'h134, 32'h20000001);
        rd_chk(12'h12C, 32'h20000001, "R2 set hi");
        wr_reg(12'h134, 32'hC0000000);
        rd_chk(12'h12C, 32'h20000001, "R2 absent channels");

        // R3 disable commands
        wr_reg(12'h138, 32'h00000012);
        rd_chk(12'h128, 32'h000000E5, "R3 clear lo");
        wr_reg(12'h13C, 32'h20000000);
        rd_chk(12'h12C, 32'h00000001, "R3 clear hi");

        // R4 status registers: channels 2, 5, 32 and 40 (40 masked)
        src[2] = 1'b1; src[5] = 1'b1; src[32] = 1'b1; src[40] = 1'b1;
        tick();
        rd_chk(12'h100, 32'h00000024, "R4 raw lo");
        rd_chk(12'h104, 32'h00000101, "R4 raw hi");
        rd_chk(12'h108, 32'h00000024, "R4 active lo");
        rd_chk(12'h10C, 32'h00000001, "R4 active hi");
        wr_reg(12'h100, 32'hFFFFFFFF);
        rd_chk(12'h100, 32'h00000024, "R4 write ignored");
        irq_chk(1'b1, "R9 pending none in service");

        // R5 priority fields
        wr_reg(12'h004, 32'h07070307);
        rd_chk(12'h004, 32'h07070307, "R5 ch5 prio");
        wr_reg(12'h020, 32'h07070701);
        rd_chk(12'h020, 32'h07070701, "R5 ch32 prio");
        wr_reg(12'h008, 32'h000000FF);
        rd_chk(12'h008, 32'h00000007, "R5 field width");

        // R7 R8 acknowledge ch32 (prio 1)
        rd_chk(12'h118, 32'h00000080, "R7 vector 32");
        irq_chk(1'b0, "R9 lower prio held off");
        rd_chk(12'h120, 32'h00000020, "R8 number 32");
        rd_chk(12'h120, 32'h00000000, "R8 clear on read");
        rd_chk(12'h118, 32'h00000000, "R7 no request reads zero");
        rd_chk(12'h120, 32'h00000000, "R8 zero latched");

        // R9 R10 preemption by ch33 at prio 0
        wr_reg(12'h020, 32'h07070001);
        wr_reg(12'h134, 32'h00000002);
        src[33] = 1'b1;
        tick();
        irq_chk(1'b1, "R9 preempt");
        rd_chk(12'h118, 32'h00000084, "R7 vector 33");
        irq_chk(1'b0, "R10 in service prio 0");
        rd_chk(12'h120, 32'h00000021, "R8 number 33");
        wr_reg(12'h150, 32'h0000DEAD);
        irq_chk(1'b1, "R10 end of service");
        rd_chk(12'h118, 32'h00000084, "R10 re-request");
        wr_reg(12'h150, 32'h0);

        // R6 channel 0 never wins
        src[32] = 1'b0; src[33] = 1'b0; src[40] = 1'b0; src[0] = 1'b1;
        wr_reg(12'h000, 32'h07070700);
        irq_chk(1'b1, "R9 ch5 pending");
        rd_chk(12'h108, 32'h00000025, "R4 active with ch0");
        rd_chk(12'h118, 32'h00000014, "R6 ch0 excluded");
        wr_reg(12'h150, 32'h0);

        // R6 tie to lower channel
        wr_reg(12'h000, 32'h07030700);
        rd_chk(12'h118, 32'h00000008, "R6 tie lower number");
        wr_reg(12'h150, 32'h0);

        // Same-cycle: ch33 rises during the acknowledge of ch5
        src[2] = 1'b0;
        tick();
        addr = 12'h118;
        rd = 1'b1;
        src[33] = 1'b1;
        exp_q.push_back(32'h00000014);
        tag_q.push_back("R7 read uses pre-edge state");
        @(negedge clk);
        rd = 1'b0;
        irq_chk(1'b1, "R9 arrival preempts in service");
        rd_chk(12'h118, 32'h00000084, "R10 nested acknowledge");
        rd_chk(12'h120, 32'h00000021, "R8 nested number");
        wr_reg(12'h150, 32'h0);
        irq_chk(1'b1, "R10 one-deep record cleared");

        // Idle, R11 unmapped
        src = '0;
        tick();
        wr_reg(12'h150, 32'h0);
        irq_chk(1'b0, "R9 nothing pending");
        rd_chk(12'h118, 32'h00000000, "R7 idle");
        rd_chk(12'h120, 32'h00000000, "R8 idle");
        rd_chk(12'h200, 32'h00000000, "R11 unmapped");
        rd_chk(12'h11C, 32'h00000000, "R11 gap");

        tick();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule